// File: doc/BRIEF.md
# Eight-bit compare timer channel

This block is one channel of a small timer. An 8-bit up-counter advances on every clock cycle in which an external count-enable input is high, and two compare registers, A and B, are checked against it in each counting cycle. Each compare register has its own 2-bit action field that decides what a match does to a single shared timer output: leave it alone, drive it low, drive it high or invert it. When both compares hit in the same cycle, a fixed priority picks the result.

The channel also keeps an overflow flag that sets when the counter wraps. Software can clear it only by first reading it as 1 and then writing 0 to it. A parameter selects whether the channel can raise a one-cycle conversion start request toward an external A/D converter on compare A. Software reaches the counter, both compare registers and the control/status register over a simple synchronous register bus with a registered read path.

Top module: `tmr8_ch`

## Requirements
- R1: After reset the counter reads 0x00, both compare registers read 0xFF, `tmr_out`, `out_en` and `adc_start` are 0, and the control register reads 0x00 on a channel with the trigger (0x10 on a channel without it).
- R2: The counter adds one on each clock edge at which `cnt_en` is high, wraps from 0xFF to 0x00, holds while `cnt_en` is low, and loads the bus data on a write to address 1.
- R3: Control bit 5 (overflow flag) becomes 1 at the edge where the counter wraps from 0xFF to 0x00.
- R4: The overflow flag clears only on a control write with bit 5 equal to 0 that follows a control read that returned bit 5 as 1. A write of 0 without that read leaves it set, and a write of 1 never sets it.
- R5: If the counter wraps again between that read and the write, the flag stays set after the write.
- R6: Control bits 1:0 give the action for compare A and bits 3:2 the action for compare B: 00 hold, 01 drive 0, 10 drive 1, 11 invert. A compare hits only in a cycle where `cnt_en` is high and the counter equals the compare register, and `tmr_out` shows the result after the next clock edge.
- R7: When A and B hit in the same cycle, invert ranks above drive 1, and drive 1 ranks above drive 0.
- R8: `out_en` is 1 exactly when at least one of control bits 3:0 is 1.
- R9: `tmr_out` is 0 from reset until the first hit and keeps its level in any cycle with no hit whose action changes it.
- R10: On a channel with the trigger, `adc_start` is high during exactly the cycles in which compare A hits while control bit 4 is 1. A compare B hit never raises it.
- R11: On a channel without the trigger, control bit 4 always reads 1, writes to it have no effect, and `adc_start` stays 0.
- R12: The register map is address 0 control, 1 counter, 2 compare A, 3 compare B. Read data appears on `bus_rdata` one cycle after the read request, and control bits 7:6 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; the counter advances and compares are checked while high |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| tmr_out | output | 1 | Timer output level |
| out_en | output | 1 | High when any compare action is selected |
| adc_start | output | 1 | One-cycle A/D conversion start request |

## Verification
On every cycle the assertions check that the counter steps by one while counting, that a wrap sets the overflow flag, that the flag only falls after an armed control write, that the output holds when nothing hits and flips when an invert action hits, and that a start request only comes in a counting cycle. The scenarios are needed for what depends on a software sequence or on specific values: the read-then-write clear and its blocking by a new wrap, each action code on each compare, the priority between simultaneous hits, the register map and read latency, and the reserved trigger bit on the second channel variant.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 2'd3;

  localparam int B_OVF  = 5;
  localparam int B_TRIG = 4;
endpackage

// File: rtl/tmr8_cnt.sv
module tmr8_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap = cnt_en && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !load) |=> (cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      cnt_val,
  input  logic              wrap,
  output logic [W-1:0]      cmp_a,
  output logic [W-1:0]      cmp_b,
  output act_e              act_a,
  output act_e              act_b,
  output logic              trig_en,
  output logic              cnt_load,
  output logic [W-1:0]      bus_rdata
);
  localparam int PAD = W - 6;

  logic ovf, armed, trig_rd;
  logic ctrl_wr, ctrl_rd;
  logic unused_wbits;

  assign ctrl_wr  = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
  assign ctrl_rd  = bus_sel && !bus_wr && (bus_addr == A_CTRL);
  assign cnt_load = bus_sel &&  bus_wr && (bus_addr == A_CNT);
  assign unused_wbits = &{1'b0, bus_wdata[W-1:6]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a <= '1;
      cmp_b <= '1;
      act_a <= ACT_HOLD;
      act_b <= ACT_HOLD;
    end else if (bus_sel && bus_wr) begin
      case (bus_addr)
        A_CMPA: cmp_a <= bus_wdata;
        A_CMPB: cmp_b <= bus_wdata;
        A_CTRL: begin
          act_a <= act_e'(bus_wdata[1:0]);
          act_b <= act_e'(bus_wdata[3:2]);
        end
        default: ;
      endcase
    end
  end

  // overflow flag with read-then-write clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (wrap)                                      ovf <= 1'b1;
      else if (ctrl_wr && armed && !bus_wdata[B_OVF]) ovf <= 1'b0;
      if (wrap || ctrl_wr)     armed <= 1'b0;
      else if (ctrl_rd && ovf) armed <= 1'b1;
    end
  end

  generate
    if (HAS_TRIG) begin : g_trig
      always_ff @(posedge clk) begin
        if (rst)          trig_en <= 1'b0;
        else if (ctrl_wr) trig_en <= bus_wdata[B_TRIG];
      end
      assign trig_rd = trig_en;
    end else begin : g_notrig
      assign trig_en = 1'b0;
      assign trig_rd = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= {{PAD{1'b0}}, ovf, trig_rd, act_b, act_a};
        A_CNT:   bus_rdata <= cnt_val;
        A_CMPA:  bus_rdata <= cmp_a;
        default: bus_rdata <= cmp_b;
      endcase
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf); // R3
  AST_OVF_ARMED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf) |-> $past(ctrl_wr && armed && !bus_wdata[B_OVF])); // R4
  AST_OVF_RACE: assert property (@(posedge clk) disable iff (rst)
    (wrap && ctrl_wr) |=> ovf); // R5
endmodule

// File: rtl/tmr8_out.sv
module tmr8_out
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_a,
  input  logic hit_b,
  input  act_e act_a,
  input  act_e act_b,
  output logic level
);
  logic do_flip, do_high, do_low, nxt;

  always_comb begin
    do_flip = (hit_a && act_a == ACT_FLIP) || (hit_b && act_b == ACT_FLIP);
    do_high = (hit_a && act_a == ACT_HIGH) || (hit_b && act_b == ACT_HIGH);
    do_low  = (hit_a && act_a == ACT_LOW)  || (hit_b && act_b == ACT_LOW);
    if (do_flip)      nxt = ~level;
    else if (do_high) nxt = 1'b1;
    else if (do_low)  nxt = 1'b0;
    else              nxt = level;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= nxt;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hit_a && !hit_b) |=> (level == $past(level))); // R9
  AST_FLIP_WINS: assert property (@(posedge clk) disable iff (rst)
    ((hit_a && act_a == ACT_FLIP) || (hit_b && act_b == ACT_FLIP)) |=> (level != $past(level))); // R7
endmodule

// File: rtl/tmr8_ch.sv
module tmr8_ch
  import tmr8_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              tmr_out,
  output logic              out_en,
  output logic              adc_start
);
  logic [W-1:0] cnt, cmp_a, cmp_b;
  logic         wrap, cnt_load, trig_en, hit_a, hit_b;
  act_e         act_a, act_b;

  tmr8_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load(cnt_load),
    .load_val(bus_wdata), .cnt(cnt), .wrap(wrap)
  );

  tmr8_regs #(.W(W), .HAS_TRIG(HAS_TRIG)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt), .wrap(wrap),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
    .trig_en(trig_en), .cnt_load(cnt_load), .bus_rdata(bus_rdata)
  );

  assign hit_a = cnt_en && (cnt == cmp_a);
  assign hit_b = cnt_en && (cnt == cmp_b);

  tmr8_out u_out (
    .clk(clk), .rst(rst), .hit_a(hit_a), .hit_b(hit_b),
    .act_a(act_a), .act_b(act_b), .level(tmr_out)
  );

  assign out_en    = (act_a != ACT_HOLD) || (act_b != ACT_HOLD);
  assign adc_start = hit_a && trig_en;

  AST_TRIG_COUNTING: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> cnt_en); // R10
  AST_OUT_EN_ACTS: assert property (@(posedge clk) disable iff (rst)
    (act_a == ACT_HOLD && act_b == ACT_HOLD) |-> !out_en); // R8
endmodule

// File: tb/tb_tmr8_ch.sv
module tb_tmr8_ch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata0, rdata1;
  logic       out0, oen0, trig0, out1, oen1, trig1;
  logic       last_trig, last_trig1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr8_ch #(.W(8), .HAS_TRIG(1'b1)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_sel(sel0), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0),
    .tmr_out(out0), .out_en(oen0), .adc_start(trig0)
  );

  tmr8_ch #(.W(8), .HAS_TRIG(1'b0)) dut1 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_sel(sel1), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
    .tmr_out(out1), .out_en(oen1), .adc_start(trig1)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel0 = (ch == 0); sel1 = (ch == 1); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel0 = (ch == 0); sel1 = (ch == 1); wr = 1'b0; addr = a;
    @(negedge clk);
    d = (ch == 0) ? rdata0 : rdata1;
    sel0 = 1'b0; sel1 = 1'b0;
  endtask

  // one counting cycle; captures the start request seen during it
  task automatic pulse();
    @(negedge clk);
    cnt_en = 1'b1;
    #1 last_trig = trig0; last_trig1 = trig1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(0, 2'd1, v); chk("R1 counter", v, 8'h00);
    rd_reg(0, 2'd2, v); chk("R1 cmpA", v, 8'hFF);
    rd_reg(0, 2'd3, v); chk("R1 cmpB", v, 8'hFF);
    rd_reg(0, 2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(1, 2'd0, v); chk("R1 ctrl no-trig", v, 8'h10);
    chk("R1 out", {7'd0, out0}, 8'd0);
    chk("R1 out_en", {7'd0, oen0}, 8'd0);
    chk("R9 out before match", {7'd0, out0}, 8'd0);
  endtask

  task automatic t_count();
    logic [7:0] v;
    wr_reg(0, 2'd1, 8'hFD);
    rd_reg(0, 2'd1, v); chk("R2 load", v, 8'hFD);
    @(negedge clk); cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    cnt_en = 1'b0;
    rd_reg(0, 2'd1, v); chk("R2 wrap count", v, 8'h01);
    repeat (3) @(negedge clk);
    rd_reg(0, 2'd1, v); chk("R2 hold", v, 8'h01);
  endtask

  task automatic t_ovf();
    logic [7:0] v;
    wr_reg(0, 2'd0, 8'h00);               // no prior read
    rd_reg(0, 2'd0, v); chk("R3 set on wrap", v & 8'h20, 8'h20);
    chk("R4 blind write keeps", v & 8'h20, 8'h20);
    wr_reg(0, 2'd0, 8'h00);               // armed by the read above
    rd_reg(0, 2'd0, v); chk("R4 read-write clear", v & 8'h20, 8'h00);
    wr_reg(0, 2'd0, 8'h20);
    rd_reg(0, 2'd0, v); chk("R4 write one no set", v & 8'h20, 8'h00);
    wr_reg(0, 2'd1, 8'hFF); pulse();
    rd_reg(0, 2'd0, v);                   // arms
    wr_reg(0, 2'd1, 8'hFF); pulse();      // new wrap
    wr_reg(0, 2'd0, 8'h00);
    rd_reg(0, 2'd0, v); chk("R5 wrap between keeps", v & 8'h20, 8'h20);
    wr_reg(0, 2'd0, 8'h00);
    rd_reg(0, 2'd0, v); chk("R5 clear after re-read", v & 8'h20, 8'h00);
    wr_reg(0, 2'd0, 8'hFF);
    rd_reg(0, 2'd0, v); chk("R12 ctrl upper bits", v, 8'h1F);
    wr_reg(0, 2'd0, 8'h00);
  endtask

  task automatic hit_a_with(input logic [7:0] ctrl, input logic exp, input string req);
    wr_reg(0, 2'd1, 8'h40);
    wr_reg(0, 2'd0, ctrl);
    pulse();
    chk(req, {7'd0, out0}, {7'd0, exp});
  endtask

  task automatic t_actions();
    logic [7:0] v;
    wr_reg(0, 2'd2, 8'h40);
    rd_reg(0, 2'd2, v); chk("R12 cmpA addr", v, 8'h40);
    wr_reg(0, 2'd0, 8'h02);
    chk("R8 out_en on", {7'd0, oen0}, 8'd1);
    wr_reg(0, 2'd1, 8'h40);
    repeat (3) @(negedge clk);
    chk("R6 no hit without cnt_en", {7'd0, out0}, 8'd0);
    hit_a_with(8'h02, 1'b1, "R6 A drive1");
    hit_a_with(8'h01, 1'b0, "R6 A drive0");
    hit_a_with(8'h03, 1'b1, "R6 A invert");
    hit_a_with(8'h03, 1'b0, "R6 A invert again");
    hit_a_with(8'h00, 1'b0, "R6 A hold");
    chk("R8 out_en off", {7'd0, oen0}, 8'd0);
    wr_reg(0, 2'd3, 8'h50);
    wr_reg(0, 2'd1, 8'h50);
    wr_reg(0, 2'd0, 8'h08);
    pulse();
    chk("R6 B drive1", {7'd0, out0}, 8'd1);
    chk("R8 out_en from B", {7'd0, oen0}, 8'd1);
    wr_reg(0, 2'd1, 8'h10);
    pulse();
    chk("R9 no change without hit", {7'd0, out0}, 8'd1);
  endtask

  task automatic both_hit(input logic [7:0] ctrl, input logic exp, input string req);
    wr_reg(0, 2'd1, 8'h30);
    wr_reg(0, 2'd0, ctrl);
    pulse();
    chk(req, {7'd0, out0}, {7'd0, exp});
  endtask

  task automatic t_priority();
    wr_reg(0, 2'd2, 8'h30);
    wr_reg(0, 2'd3, 8'h30);
    both_hit(8'h05, 1'b0, "R7 both drive0");
    both_hit(8'h09, 1'b1, "R7 B drive1 over A drive0");
    both_hit(8'h05, 1'b0, "R7 both drive0 again");
    both_hit(8'h06, 1'b1, "R7 A drive1 over B drive0");
    both_hit(8'h0B, 1'b0, "R7 A invert over B drive1");
    both_hit(8'h0D, 1'b1, "R7 B invert over A drive0");
  endtask

  task automatic t_trig();
    wr_reg(0, 2'd2, 8'h60);
    wr_reg(0, 2'd3, 8'h70);
    wr_reg(0, 2'd1, 8'h60);
    wr_reg(0, 2'd0, 8'h11);
    pulse();
    chk("R10 start on A hit", {7'd0, last_trig}, 8'd1);
    chk("R10 one cycle", {7'd0, trig0}, 8'd0);
    wr_reg(0, 2'd1, 8'h70);
    pulse();
    chk("R10 no start on B hit", {7'd0, last_trig}, 8'd0);
    wr_reg(0, 2'd1, 8'h60);
    wr_reg(0, 2'd0, 8'h01);
    pulse();
    chk("R10 disabled", {7'd0, last_trig}, 8'd0);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr_reg(1, 2'd0, 8'h00);
    rd_reg(1, 2'd0, v); chk("R11 bit4 stays 1", v & 8'h10, 8'h10);
    wr_reg(1, 2'd2, 8'h22);
    wr_reg(1, 2'd1, 8'h22);
    wr_reg(1, 2'd0, 8'h13);
    pulse();
    chk("R11 no start", {7'd0, last_trig1}, 8'd0);
    chk("R11 compare still acts", {7'd0, out1}, 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_ovf();
    t_actions();
    t_priority();
    t_trig();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule